// File: doc/BRIEF.md
# Chip-Select Bounds Address Decoder

This block steers a physical memory address to one of a fixed set of memory chip selects. Each chip select owns a programmable window, described by a start unit and an end unit. Both count in 16 MiB steps, and the end unit is part of the window. An address arrives on a valid/ready stream. The block compares its 16 MiB unit number against every window in parallel and returns a registered result on an output stream. The result carries a one-hot chip-select vector, the encoded chip-select number and a flag raised when no populated window claims the address.

A window whose start equals its end counts as not populated and never matches. Alongside the stream, plain status pins show per chip select whether it is populated and how many 16 MiB units its window spans. Windows are loaded through a write-only register port: one 32-bit word per chip select, selected by number.

Back-pressure rules: an address is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output holds no result or the result is being taken in the same cycle. A result stays unchanged on the output until `out_ready` is seen high with `out_valid`.

Top module: `cs_bounds_decoder`

## Requirements
- R1: After reset every window is zero, so all `cs_populated` bits and all `cs_size` fields read 0. A write with `cfg_we` high loads `cfg_wdata[15:0]` as the end unit and `cfg_wdata[31:16]` as the start unit of chip select `cfg_sel`.
- R2: An address matches a populated chip select when its bits 39:24 lie between the start unit and the end unit, both included. The top unit of a window matches even with all lower address bits set.
- R3: A chip select whose start unit equals its end unit never matches and shows `cs_populated` low.
- R4: When no chip select matches, the result has `out_miss` high, `out_cs_onehot` all zero and `out_cs_idx` zero.
- R5: When several chip selects match, only the lowest-numbered one is reported, with `out_cs_onehot` bit i set and `out_cs_idx` equal to i.
- R6: `cs_size` field i (bits 17*i+16 to 17*i) equals end minus start plus one when chip select i is populated and its end is above its start, and 0 otherwise. A window whose end is below its start also never matches.
- R7: An accepted address produces its result with `out_valid` high at the next clock edge. While `out_valid` is high and `out_ready` is low, `in_ready` is low and the result holds steady.
- R8: Address bits 23:0 have no effect on the result.
- R9: A window write takes effect for any address accepted on a later clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 2 | Chip select whose window is written |
| cfg_wdata | input | 32 | Window word: start unit in 31:16, end unit in 15:0 |
| in_valid | input | 1 | Address stream valid |
| in_ready | output | 1 | Address stream ready |
| in_addr | input | 40 | Physical address |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_cs_onehot | output | 4 | One-hot selected chip select |
| out_cs_idx | output | 2 | Encoded selected chip select |
| out_miss | output | 1 | No populated window claims the address |
| cs_populated | output | 4 | Per chip select: window populated |
| cs_size | output | 68 | Per chip select, 17 bits each: window size in 16 MiB units |

## Verification
The bench builds the block with its defaults: four chip selects and a 40-bit address, so all 16 bits of each unit field reach the comparators. Random window values are kept to a small band of unit numbers. This makes overlaps, empty windows, reversed windows and addresses sitting exactly on a start or end unit frequent, rather than rare. Low address bits are randomised on every request, so their lack of effect is checked throughout.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  localparam int unsigned UNIT_W     = 16;
  localparam int unsigned GRAN_SHIFT = 24;
  localparam int unsigned WORD_W     = 2 * UNIT_W;
  localparam int unsigned SIZE_W     = UNIT_W + 1;

  typedef logic [UNIT_W-1:0] unit_t;
  typedef logic [SIZE_W-1:0] span_t;

  typedef struct packed {
    unit_t first;
    unit_t last;
  } window_t;

  function automatic window_t word_to_window(input logic [WORD_W-1:0] w);
    window_t r;
    r.first = w[WORD_W-1:UNIT_W];
    r.last  = w[UNIT_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/cs_window_regs.sv
module cs_window_regs
  import cs_dec_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic [WORD_W-1:0]           wr_word,
  output window_t [NUM_CS-1:0]        win_o
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    window_t win_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        win_q <= '0;
      else if (wr_en && (wr_sel == SEL_W'(g)))
        win_q <= word_to_window(wr_word);
    end
    assign win_o[g] = win_q;
  end

  // R1: a write lands in the selected window on the next edge
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_sel) < NUM_CS)) |=> (win_o[$past(wr_sel)] == $past(wr_word)));
endmodule

// File: rtl/cs_window_match.sv
module cs_window_match
  import cs_dec_pkg::*;
(
  input  window_t win,
  input  unit_t   unit,
  output logic    hit,
  output logic    populated,
  output span_t   span
);
  logic ordered;

  always_comb begin
    populated = (win.first != win.last);
    ordered   = (win.last > win.first);
    hit       = populated && (unit >= win.first) && (unit <= win.last);
    if (ordered)
      span = {1'b0, win.last} - {1'b0, win.first} + span_t'(1);
    else
      span = '0;
  end
endmodule

// File: rtl/cs_first_hit.sv
module cs_first_hit #(
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [NUM_CS-1:0] hits,
  output logic [NUM_CS-1:0] onehot,
  output logic [SEL_W-1:0]  sel,
  output logic              none
);
  always_comb begin
    onehot = '0;
    sel    = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        onehot    = '0;
        onehot[i] = 1'b1;
        sel       = SEL_W'(i);
      end
    end
    none = (hits == '0);
  end
endmodule

// File: rtl/cs_bounds_decoder.sv
module cs_bounds_decoder
  import cs_dec_pkg::*;
#(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned ADDR_W = 40,
  localparam int unsigned SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic [WORD_W-1:0]        cfg_wdata,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [ADDR_W-1:0]        in_addr,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NUM_CS-1:0]        out_cs_onehot,
  output logic [SEL_W-1:0]         out_cs_idx,
  output logic                     out_miss,
  output logic [NUM_CS-1:0]        cs_populated,
  output logic [NUM_CS*SIZE_W-1:0] cs_size
);
  localparam int unsigned UNIT_LSB = GRAN_SHIFT;
  localparam int unsigned UNIT_MSB = GRAN_SHIFT + UNIT_W - 1;

  window_t [NUM_CS-1:0] win;
  logic    [NUM_CS-1:0] hits;
  logic    [NUM_CS-1:0] pick_onehot;
  logic    [SEL_W-1:0]  pick_sel;
  logic                 pick_none;
  unit_t                addr_unit;

  assign addr_unit = in_addr[UNIT_MSB:UNIT_LSB];

  cs_window_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_word (cfg_wdata),
    .win_o   (win)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    cs_window_match u_match (
      .win       (win[g]),
      .unit      (addr_unit),
      .hit       (hits[g]),
      .populated (cs_populated[g]),
      .span      (cs_size[g*SIZE_W +: SIZE_W])
    );
  end

  cs_first_hit #(.NUM_CS(NUM_CS)) u_pick (
    .hits   (hits),
    .onehot (pick_onehot),
    .sel    (pick_sel),
    .none   (pick_none)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_cs_onehot <= '0;
      out_cs_idx    <= '0;
      out_miss      <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_cs_onehot <= pick_onehot;
        out_cs_idx    <= pick_sel;
        out_miss      <= pick_none;
      end
    end
  end

  // R7: accepted address yields a result next cycle
  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7: stalled result stays put
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cs_onehot)
                                   && $stable(out_cs_idx) && $stable(out_miss)));

  // R5: at most one chip select reported
  assert_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_cs_onehot));

  // R5: encoded number agrees with the one-hot vector
  assert_idx_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_miss) |-> out_cs_onehot[out_cs_idx]);

  // R4: miss carries an empty selection
  assert_miss_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_miss == (out_cs_onehot == '0)));
endmodule

// File: tb/cs_bounds_decoder_test.sv
module cs_bounds_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [39:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_cs_onehot;
  logic [1:0]  out_cs_idx;
  logic        out_miss;
  logic [3:0]  cs_populated;
  logic [67:0] cs_size;

  int n_checks = 0;
  int n_fail = 0;
  int b_start [4];
  int b_end   [4];

  always #4 clk = ~clk;

  cs_bounds_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_cs_onehot(out_cs_onehot), .out_cs_idx(out_cs_idx),
    .out_miss(out_miss), .cs_populated(cs_populated), .cs_size(cs_size)
  );

  function automatic int exp_pick(input logic [39:0] a);
    int u = int'(a[39:24]);
    for (int i = 0; i < 4; i++)
      if (b_start[i] != b_end[i] && u >= b_start[i] && u <= b_end[i])
        return i;
    return -1;
  endfunction

  function automatic int exp_size(input int i);
    return (b_end[i] > b_start[i]) ? (b_end[i] - b_start[i] + 1) : 0;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_win(input int i, input int s, input int e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(i); cfg_wdata = {16'(s), 16'(e)};
    @(negedge clk);
    cfg_we = 1'b0;
    b_start[i] = s; b_end[i] = e;
  endtask

  task automatic check_result(input logic [39:0] a, input string tag);
    int p = exp_pick(a);
    logic [3:0] eh = (p < 0) ? 4'b0 : 4'(1 << p);
    logic [1:0] ei = (p < 0) ? 2'd0 : 2'(p);
    check(out_valid === 1'b1, {tag, " valid"}, longint'(out_valid), 1);
    check(out_cs_onehot === eh && out_cs_idx === ei && out_miss === (p < 0),
          tag, longint'({out_miss, out_cs_idx, out_cs_onehot}),
          longint'({p < 0, ei, eh}));
  endtask

  task automatic send(input logic [39:0] a, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_result(a, tag);
  endtask

  task automatic check_status(input string tag);
    for (int i = 0; i < 4; i++) begin
      check(cs_populated[i] === (b_start[i] != b_end[i]), {tag, " populated"},
            longint'(cs_populated[i]), longint'(b_start[i] != b_end[i]));
      check(cs_size[i*17 +: 17] === 17'(exp_size(i)), {tag, " size"},
            longint'(cs_size[i*17 +: 17]), longint'(exp_size(i)));
    end
  endtask

  function automatic logic [39:0] mk(input int u, input logic [23:0] low);
    return {16'(u), low};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [39:0] a1, a2;
    void'($urandom(32'h00c5_0b0d));
    for (int i = 0; i < 4; i++) begin b_start[i] = 0; b_end[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0, "R1 reset out_valid", longint'(out_valid), 0);
    check(in_ready === 1'b1, "R7 reset in_ready", longint'(in_ready), 1);
    check_status("R1 reset");
    send(mk(0, 24'h123456), "R4 miss with all unpopulated");

    // R1/R2: program and probe boundaries
    write_win(0, 4, 7);
    write_win(1, 10, 10);   // R3 empty
    write_win(2, 6, 12);    // overlaps 0
    write_win(3, 9, 2);     // R6 reversed
    check_status("R1 R6 after writes");
    send(mk(4, 24'h0), "R2 start unit");
    send(mk(3, 24'hffffff), "R4 below start");
    send(mk(7, 24'hffffff), "R2 end inclusive");
    send(mk(6, 24'h000001), "R5 overlap lowest wins");
    send(mk(8, 24'h0), "R5 only higher window");
    send(mk(10, 24'h7), "R3 start equals end ignored");
    send(mk(13, 24'h0), "R4 above all");
    send(mk(2, 24'h0), "R6 reversed window never matches");
    send(mk(12, 24'h000000), "R8 low bits zero");
    send(mk(12, 24'hffffff), "R8 low bits ones");

    // R9: write then address on next edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = {16'd20, 16'd30};
    @(negedge clk);
    cfg_we = 1'b0; b_start[3] = 20; b_end[3] = 30;
    in_valid = 1'b1; in_addr = mk(25, 24'h0);
    @(negedge clk);
    in_valid = 1'b0;
    check_result(mk(25, 24'h0), "R9 new window used");

    // R7: back-pressure
    a1 = mk(5, 24'h42); a2 = mk(11, 24'h99);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_addr = a1;
    @(negedge clk);
    in_addr = a2;
    check(in_ready === 1'b0, "R7 stalled in_ready", longint'(in_ready), 0);
    @(negedge clk);
    @(negedge clk);
    check_result(a1, "R7 held result");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_result(a2, "R7 next result after release");

    // random mix
    for (int r = 0; r < 300; r++) begin
      if (r % 20 == 0) begin
        for (int i = 0; i < 4; i++)
          write_win(i, int'($urandom % 12), int'($urandom % 14));
        check_status("R1 R3 R6 random status");
      end
      send(mk(int'($urandom % 16), 24'($urandom)), "R2 R5 R8 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule